// File: doc/BRIEF.md
# Power-Good Reset and Bus-Isolation Timer

This block sits on a hot-pluggable card next to the supply switch controller. It takes the digitised power-good flag of the lower supply together with a set of hard fault and presence conditions. From them it drives three outputs: the active-low system reset, the active-high bus isolation (disable) signal and a registered copy of power-good. The analog comparators and the open-drain output stages are outside the block; every input is a synchronous logic level.

Release and assertion are deliberately asymmetric. Reset and disable are released only after power-good has been high, with every hard condition absent, for a long run of consecutive clock ticks. Any hard condition forces both outputs back to the asserted state on the next edge. A loss of power-good isolates the bus at once, but it asserts reset only after a short run of consecutive low samples, so a brief dip does not reset the system. All three delays are parameters in clock ticks. The defaults are 200 ms for release and 32 µs for the power-fail delay at a 125 MHz clock.

Top module: `supply_reset_timer`

## Requirements
- R1: `pg_out` equals the value `pg_raw` had at the previous clock edge in both directions, with no further delay.
- R2: If at a clock edge any hard condition holds (`conn_a` = 1, `conn_b` = 1, `rst_req_n` = 0, `uvlo_lo` = 1, `uvlo_hi` = 1 or `oc_fault` = 1), then after that edge `rst_out_n` = 0 and `bus_dis` = 1, and both release counts restart from zero.
- R3: `rst_out_n` rises at the RST_TICKS-th consecutive edge at which `pg_raw` = 1 and no hard condition holds. Any edge that breaks the run restarts the count.
- R4: `bus_dis` falls at the DIS_TICKS-th consecutive edge of the same run as in R3, counted independently of RST_TICKS.
- R5: An edge with `pg_raw` = 0 sets `bus_dis` = 1 after that edge, even while `rst_out_n` is still high.
- R6: With no hard condition, `rst_out_n` falls at the FALL_TICKS-th consecutive edge with `pg_raw` = 0. A shorter low run leaves `rst_out_n` high.
- R7: While `rst_n` = 0 at a clock edge, after that edge `rst_out_n` = 0, `bus_dis` = 1, `pg_out` = 0 and all counts are cleared.
- R8: Once released, `rst_out_n` stays high for as long as `pg_raw` = 1 and no hard condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| pg_raw | input | 1 | Power-good comparator flag, lower supply (1 = good) |
| conn_a | input | 1 | First presence contact, 1 = not connected |
| conn_b | input | 1 | Second presence contact, 1 = not connected |
| rst_req_n | input | 1 | Reset request, active low |
| uvlo_lo | input | 1 | Lower supply in undervoltage lockout |
| uvlo_hi | input | 1 | Upper supply in undervoltage lockout |
| oc_fault | input | 1 | Latched overcurrent fault |
| rst_out_n | output | 1 | System reset, active low |
| bus_dis | output | 1 | Data bus isolation, 1 = isolated |
| pg_out | output | 1 | Registered power-good |

## Verification
Most internal faults in this block show up as timing errors at the outputs. If the release count fails to restart, `rst_out_n` or `bus_dis` releases early after an interrupted run. This shows within RST_TICKS or DIS_TICKS cycles of the interruption. If the power-fail count is wrong, reset either follows a short dip or lags a real outage, and this shows within FALL_TICKS cycles. A wrong hard-condition decode shows one edge after the offending input changes. The bench compares all three outputs against a behavioural model on every cycle. A divergence is therefore reported in the first cycle where it is visible.

// File: rtl/sr_timer_pkg.sv
package sr_timer_pkg;
    // Number of hard conditions that force reset without delay.
    localparam int unsigned NUM_HARD = 6;
    // Bit order of the hard-condition vector.
    localparam int unsigned IDX_CONN_A = 0;
    localparam int unsigned IDX_CONN_B = 1;
    localparam int unsigned IDX_REQ_N  = 2;
    localparam int unsigned IDX_UVLO_L = 3;
    localparam int unsigned IDX_UVLO_H = 4;
    localparam int unsigned IDX_OC     = 5;
    // Polarity mask: a set bit means the condition is active when the input is low.
    localparam logic [NUM_HARD-1:0] HARD_ACT_LOW = 6'b000100;

    typedef logic [NUM_HARD-1:0] hard_vec_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sr_hard_merge.sv
module sr_hard_merge #(
    parameter int unsigned N = 6,
    parameter logic [N-1:0] ACT_LOW = '0
) (
    input  logic [N-1:0] raw,
    output logic         any_active
);
    logic [N-1:0] active;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pol
            if (ACT_LOW[i]) begin : g_low
                assign active[i] = ~raw[i];
            end else begin : g_high
                assign active[i] = raw[i];
            end
        end
    endgenerate

    assign any_active = |active;
endmodule

// File: rtl/sr_tick_reached.sv
module sr_tick_reached #(
    parameter int unsigned W     = 8,
    parameter int unsigned LIMIT = 1
) (
    input  logic [W-1:0] count,
    output logic         hit
);
    localparam logic [W-1:0] LIM = W'(LIMIT);
    assign hit = (count >= LIM);
endmodule

// File: rtl/supply_reset_timer.sv
module supply_reset_timer
    import sr_timer_pkg::*;
#(
    parameter int unsigned RST_TICKS  = 25_000_000,
    parameter int unsigned DIS_TICKS  = 25_000_000,
    parameter int unsigned FALL_TICKS = 4_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_raw,
    input  logic conn_a,
    input  logic conn_b,
    input  logic rst_req_n,
    input  logic uvlo_lo,
    input  logic uvlo_hi,
    input  logic oc_fault,
    output logic rst_out_n,
    output logic bus_dis,
    output logic pg_out
);
    localparam int unsigned REL_MAX = max2(RST_TICKS, DIS_TICKS);
    localparam int unsigned RW      = $clog2(REL_MAX + 1);
    localparam int unsigned FW      = $clog2(FALL_TICKS + 1);
    localparam logic [RW-1:0] REL_CAP = RW'(REL_MAX);

    typedef struct packed {
        logic          pg;
        logic          rst_n;
        logic          dis;
        logic [RW-1:0] rel;
        logic [FW-1:0] fall;
    } st_t;

    localparam st_t RESET_ST = '{pg: 1'b0, rst_n: 1'b0, dis: 1'b1, rel: '0, fall: '0};

    st_t st_q, st_d;

    hard_vec_t hard_vec;
    logic      hard_any;
    logic [RW-1:0] rel_inc;
    logic [FW-1:0] fall_inc;
    logic      hit_rst, hit_dis, hit_fall;

    always_comb begin
        hard_vec             = '0;
        hard_vec[IDX_CONN_A] = conn_a;
        hard_vec[IDX_CONN_B] = conn_b;
        hard_vec[IDX_REQ_N]  = rst_req_n;
        hard_vec[IDX_UVLO_L] = uvlo_lo;
        hard_vec[IDX_UVLO_H] = uvlo_hi;
        hard_vec[IDX_OC]     = oc_fault;
    end

    sr_hard_merge #(
        .N       (NUM_HARD),
        .ACT_LOW (HARD_ACT_LOW)
    ) u_merge (
        .raw        (hard_vec),
        .any_active (hard_any)
    );

    assign rel_inc  = (st_q.rel < REL_CAP) ? st_q.rel + 1'b1 : st_q.rel;
    assign fall_inc = st_q.fall + 1'b1;

    sr_tick_reached #(.W(RW), .LIMIT(RST_TICKS))  u_hit_rst  (.count(rel_inc),  .hit(hit_rst));
    sr_tick_reached #(.W(RW), .LIMIT(DIS_TICKS))  u_hit_dis  (.count(rel_inc),  .hit(hit_dis));
    sr_tick_reached #(.W(FW), .LIMIT(FALL_TICKS)) u_hit_fall (.count(fall_inc), .hit(hit_fall));

    always_comb begin
        st_d    = st_q;
        st_d.pg = pg_raw;
        if (hard_any) begin
            st_d.rst_n = 1'b0;
            st_d.dis   = 1'b1;
            st_d.rel   = '0;
            st_d.fall  = '0;
        end else if (!pg_raw) begin
            st_d.rel = '0;
            st_d.dis = 1'b1;
            if (!st_q.rst_n) begin
                st_d.fall = '0;
            end else if (hit_fall) begin
                st_d.rst_n = 1'b0;
                st_d.fall  = '0;
            end else begin
                st_d.fall = fall_inc;
            end
        end else begin
            st_d.fall = '0;
            if (!(st_q.rst_n && !st_q.dis)) begin
                st_d.rel = rel_inc;
                if (hit_rst) st_d.rst_n = 1'b1;
                if (hit_dis) st_d.dis   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign rst_out_n = st_q.rst_n;
    assign bus_dis   = st_q.dis;
    assign pg_out    = st_q.pg;
endmodule

// File: rtl/sr_timer_chk.sv
module sr_timer_chk #(
    parameter int unsigned FALL_TICKS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic pg_raw,
    input logic conn_a,
    input logic conn_b,
    input logic rst_req_n,
    input logic uvlo_lo,
    input logic uvlo_hi,
    input logic oc_fault,
    input logic rst_out_n,
    input logic bus_dis,
    input logic pg_out
);
    logic hard;
    assign hard = conn_a | conn_b | ~rst_req_n | uvlo_lo | uvlo_hi | oc_fault;

    p_pg_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pg_out == $past(pg_raw)));

    p_hard_forces_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hard |=> (!rst_out_n && bus_dis));

    p_release_needs_pg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> pg_out);

    p_dis_on_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_raw |=> bus_dis);

    p_no_instant_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((FALL_TICKS > 1) && rst_out_n && pg_out && !pg_raw && !hard) |=> rst_out_n);

    p_hold_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out_n && pg_raw && !hard) |=> rst_out_n);
endmodule

bind supply_reset_timer sr_timer_chk #(.FALL_TICKS(FALL_TICKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pg_raw    (pg_raw),
    .conn_a    (conn_a),
    .conn_b    (conn_b),
    .rst_req_n (rst_req_n),
    .uvlo_lo   (uvlo_lo),
    .uvlo_hi   (uvlo_hi),
    .oc_fault  (oc_fault),
    .rst_out_n (rst_out_n),
    .bus_dis   (bus_dis),
    .pg_out    (pg_out)
);

// File: tb/supply_reset_timer_tb.sv
`timescale 1ns/1ps
module supply_reset_timer_tb;
    localparam int RST_T  = 20;
    localparam int DIS_T  = 16;
    localparam int FALL_T = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg_raw = 1'b0;
    logic conn_a = 1'b1, conn_b = 1'b1, rst_req_n = 1'b1;
    logic uvlo_lo = 1'b0, uvlo_hi = 1'b0, oc_fault = 1'b0;
    logic rst_out_n, bus_dis, pg_out;

    int tests = 0;
    int fails = 0;
    string tag = "R7 reset";

    always #4 clk = ~clk;

    supply_reset_timer #(
        .RST_TICKS(RST_T), .DIS_TICKS(DIS_T), .FALL_TICKS(FALL_T)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pg_raw(pg_raw),
        .conn_a(conn_a), .conn_b(conn_b), .rst_req_n(rst_req_n),
        .uvlo_lo(uvlo_lo), .uvlo_hi(uvlo_hi), .oc_fault(oc_fault),
        .rst_out_n(rst_out_n), .bus_dis(bus_dis), .pg_out(pg_out)
    );

    // Behavioural reference: good-run length and low-run length as plain integers.
    int  good_run = 0;
    int  low_run  = 0;
    bit  m_rst_n  = 0;
    bit  m_dis    = 1;
    bit  m_pg     = 0;

    always @(posedge clk) begin
        bit hard;
        hard = conn_a || conn_b || !rst_req_n || uvlo_lo || uvlo_hi || oc_fault;
        if (!rst_n) begin
            m_rst_n = 0; m_dis = 1; m_pg = 0; good_run = 0; low_run = 0;
        end else begin
            m_pg = pg_raw;
            if (hard) begin
                m_rst_n = 0; m_dis = 1; good_run = 0; low_run = 0;
            end else if (!pg_raw) begin
                good_run = 0;
                m_dis = 1;
                if (m_rst_n) begin
                    low_run++;
                    if (low_run >= FALL_T) begin m_rst_n = 0; low_run = 0; end
                end else low_run = 0;
            end else begin
                low_run = 0;
                good_run++;
                if (good_run >= RST_T) m_rst_n = 1;
                if (good_run >= DIS_T) m_dis = 0;
            end
        end
    end

    task automatic check_all();
        tests++;
        if (rst_out_n !== m_rst_n) begin
            fails++;
            $display("FAIL %s rst_out_n actual=%b expected=%b t=%0t", tag, rst_out_n, m_rst_n, $time);
        end
        tests++;
        if (bus_dis !== m_dis) begin
            fails++;
            $display("FAIL %s bus_dis actual=%b expected=%b t=%0t", tag, bus_dis, m_dis, $time);
        end
        tests++;
        if (pg_out !== m_pg) begin
            fails++;
            $display("FAIL R1 (%s) pg_out actual=%b expected=%b t=%0t", tag, pg_out, m_pg, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            check_all();
        end
    endtask

    task automatic all_good();
        conn_a = 0; conn_b = 0; rst_req_n = 1;
        uvlo_lo = 0; uvlo_hi = 0; oc_fault = 0; pg_raw = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R7: reset state
        tag = "R7 reset";
        pg_raw = 1;
        step(3);
        rst_n = 1;
        // R2: still unplugged, reset held
        tag = "R2 unplugged";
        step(5);
        // R3/R4/R8: clean power-up, release and hold
        tag = "R3 R4 R8 power-up";
        all_good();
        step(30);
        // R5/R6: short dip below FALL_T keeps reset high, disable asserts
        tag = "R5 R6 short dip";
        pg_raw = 0;
        step(FALL_T - 1);
        pg_raw = 1;
        tag = "R4 re-release";
        step(DIS_T + 4);
        // R6: long outage asserts reset after FALL_T
        tag = "R6 outage";
        pg_raw = 0;
        step(FALL_T + 3);
        // R3: interrupted wait restarts
        tag = "R3 restart";
        pg_raw = 1;
        step(10);
        conn_b = 1;
        step(1);
        conn_b = 0;
        step(RST_T - 2);
        pg_raw = 0;
        step(1);
        pg_raw = 1;
        step(RST_T + 4);
        // R2: each hard condition in turn
        for (int c = 0; c < 6; c++) begin
            tag = "R2 hard cond";
            case (c)
                0: conn_a = 1;
                1: conn_b = 1;
                2: rst_req_n = 0;
                3: uvlo_lo = 1;
                4: uvlo_hi = 1;
                default: oc_fault = 1;
            endcase
            step(2);
            all_good();
            tag = "R3 R8 recover";
            step(RST_T + 2);
        end
        // R1: pg toggling with hard condition present
        tag = "R1 pg follow";
        oc_fault = 1;
        for (int k = 0; k < 6; k++) begin
            pg_raw = k[0];
            step(1);
        end
        all_good();
        step(RST_T + 2);
        // R7: synchronous reset mid-run
        tag = "R7 mid reset";
        rst_n = 0;
        step(2);
        rst_n = 1;
        tag = "R3 after reset";
        step(RST_T + 3);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule